// File: doc/BRIEF.md
# Optical Black Clamp Loop Controller

The block is a digital servo that removes residual offset from an image-sensor pixel stream. It watches the 12-bit converter output during the shielded (black) pixels at the start of each line. It compares each code there with a programmable black target and turns the filtered error into an 8-bit correction code. That code drives an offset DAC placed ahead of the converter.

A window strobe marks the black pixels. Its active level is chosen by an input. Inside a window the controller sums the signed error, target minus sample, over the first 2^AVG_LOG samples. When the window closes, it turns the sum into an average-based step and adds that step to the correction, clamped to the code range. A line divider lets the update run once every N windows. When the loop is switched off, the correction register follows the programmed target and acts as a fixed open-loop offset.

Top module: `obclamp_loop`

## Requirements
- R1: After `rst_n` is asserted, `corr` is 128 and the internal target register is 128.
- R2: A cycle with `tgt_ld` high stores `tgt_data` as the target on that clock edge.
- R3: While the loop is enabled, `corr` changes only on the clock edge at which the window goes from active to inactive. Samples outside the window have no effect.
- R4: The window is active when `win_in` equals `win_pol`. So `win_pol`=1 selects active high and `win_pol`=0 selects active low.
- R5: At each update edge, let n = min(samples in the window, 2^AVG_LOG) and let A be the sum of (target − sample) over those first n samples. The step is sign(A)·(|A| >> (floor(log2 n) + GAIN_SH)), and `corr` takes the old value plus the step. With the defaults, AVG_LOG=4 and GAIN_SH=2.
- R6: The new correction is clamped to the range 0 to 255.
- R7: `line_div` = N applies an update on every N-th closed window and discards the other windows. A value of 0 acts as 1. The window count restarts after each update.
- R8: While `loop_off` is high, `corr` takes the target register value on every edge, and windows are ignored. The window count and the sum are cleared.
- R9: A cycle with `soft_rst` high sets `corr` and the target to 128 on that edge and clears the window count and the sum.
- R10: A window only one sample long still produces a valid update, with n = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous software reset to mid-scale |
| sample | input | 12 | Converter output code |
| win_in | input | 1 | Black-pixel window strobe |
| win_pol | input | 1 | Active level of the window strobe |
| tgt_ld | input | 1 | Load strobe for the target register |
| tgt_data | input | 8 | New target black level |
| loop_off | input | 1 | Disables the loop and selects open-loop offset |
| line_div | input | 4 | Windows per update (0 acts as 1) |
| corr | output | 8 | Registered correction code for the offset DAC |

## Verification
A window update is due on the edge that first sees the strobe inactive. The bench drives that inactive level at a falling edge and reads `corr` at the next falling edge. A target load in open loop needs two edges, one into the target register and one into `corr`, so the load task waits for both before it checks. A soft reset is due after one edge. Idle gaps and skipped windows are checked at the falling edge that follows them, where `corr` must still hold the value the bench model predicts.

// File: rtl/obclamp_loop.sv
module obclamp_loop #(
  parameter int SAMP_W   = 12,
  parameter int CODE_W   = 8,
  parameter int ACC_W    = 18,
  parameter int AVG_LOG  = 4,
  parameter int GAIN_SH  = 2,
  parameter int DIV_W    = 4,
  parameter int RST_CODE = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [SAMP_W-1:0] sample,
  input  logic              win_in,
  input  logic              win_pol,
  input  logic              tgt_ld,
  input  logic [CODE_W-1:0] tgt_data,
  input  logic              loop_off,
  input  logic [DIV_W-1:0]  line_div,
  output logic [CODE_W-1:0] corr
);
  localparam int CNT_W = AVG_LOG + 1;
  localparam int LG_W  = $clog2(CNT_W) + 1;
  localparam int SUM_W = ACC_W + 2;
  localparam logic [CNT_W-1:0]  CNT_MAX = {1'b1, {AVG_LOG{1'b0}}};
  localparam logic [CODE_W-1:0] MID     = RST_CODE[CODE_W-1:0];

  logic [CODE_W-1:0]       tgt_q;
  logic signed [ACC_W-1:0] acc;
  logic [CNT_W-1:0]        cnt;
  logic [DIV_W-1:0]        line_cnt;
  logic                    win_q;

  logic win_act, win_end, take, fire;
  assign win_act = (win_in == win_pol);
  assign win_end = win_q & ~win_act;
  assign take    = win_act & (cnt < CNT_MAX);

  logic signed [SAMP_W:0] err;
  assign err = $signed({1'b0, {(SAMP_W-CODE_W){1'b0}}, tgt_q}) - $signed({1'b0, sample});

  logic [LG_W-1:0] lg;
  always_comb begin
    lg = '0;
    for (int i = 0; i < CNT_W; i++)
      if (cnt[i]) lg = LG_W'(i);
  end

  logic [7:0]         sh;
  logic               neg;
  logic [ACC_W-1:0]   mag, step;
  logic signed [SUM_W-1:0] sum;
  logic [CODE_W-1:0]  nxt;

  assign sh   = 8'(lg) + 8'(GAIN_SH);
  assign neg  = acc[ACC_W-1];
  assign mag  = neg ? ACC_W'(-acc) : ACC_W'(acc);
  assign step = mag >> sh;
  assign sum  = $signed({{(SUM_W-CODE_W){1'b0}}, corr}) +
                (neg ? -$signed({2'b00, step}) : $signed({2'b00, step}));
  assign nxt  = sum[SUM_W-1] ? '0 :
                (|sum[SUM_W-2:CODE_W]) ? '1 : sum[CODE_W-1:0];

  logic [DIV_W:0] line_next, div_eff;
  assign line_next = {1'b0, line_cnt} + 1'b1;
  assign div_eff   = (line_div == '0) ? (DIV_W+1)'(1) : {1'b0, line_div};
  assign fire      = line_next >= div_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= MID;  corr <= MID;
      acc <= '0;  cnt <= '0;  line_cnt <= '0;  win_q <= 1'b0;
    end else begin
      win_q <= win_act;
      if (soft_rst) begin
        tgt_q <= MID;  corr <= MID;
        acc <= '0;  cnt <= '0;  line_cnt <= '0;
      end else begin
        if (tgt_ld) tgt_q <= tgt_data;
        if (loop_off) begin
          corr <= tgt_q;
          acc <= '0;  cnt <= '0;  line_cnt <= '0;
        end else if (win_end) begin
          acc <= '0;  cnt <= '0;
          if (fire) begin
            corr     <= nxt;
            line_cnt <= '0;
          end else begin
            line_cnt <= line_next[DIV_W-1:0];
          end
        end else if (take) begin
          acc <= acc + {{(ACC_W-SAMP_W-1){err[SAMP_W]}}, err};
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R3
  corr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !loop_off && !win_end) |=> $stable(corr));

  // R8
  open_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_off && !soft_rst) |=> corr == $past(tgt_q));

  // R9
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (corr == MID && tgt_q == MID && line_cnt == '0));

  // R10
  nonempty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !loop_off && !soft_rst) |-> cnt != '0);
endmodule

// File: tb/obclamp_loop_tb.sv
module obclamp_loop_tb;
  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic [11:0] sample = '0;
  logic win_in = 1'b0, win_pol = 1'b1, tgt_ld = 1'b0, loop_off = 1'b0;
  logic [7:0] tgt_data = '0;
  logic [3:0] line_div = '0;
  logic [7:0] corr;

  int tests = 0, fails = 0, seed_dummy;
  int corr_m = 128, tgt_m = 128, lcnt = 0;
  bit done = 0;

  obclamp_loop u_dut (.clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sample(sample),
    .win_in(win_in), .win_pol(win_pol), .tgt_ld(tgt_ld), .tgt_data(tgt_data),
    .loop_off(loop_off), .line_div(line_div), .corr(corr));

  always #5 clk = ~clk;

  function automatic int upd(int c, int a, int n);
    int lg = 0, m, s, r;
    for (int i = 0; i < 5; i++) if ((n >> i) & 1) lg = i;
    m = (a < 0) ? -a : a;
    s = m >> (lg + 2);
    r = c + ((a < 0) ? -s : s);
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_window(int len, int lo, int hi, string req);
    int a = 0, n = 0, eff;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      win_in = win_pol;
      sample = 12'(lo + int'($urandom % (hi - lo + 1)));
      if (n < 16) begin a += tgt_m - int'(sample); n++; end
    end
    @(negedge clk);
    win_in = ~win_pol;
    sample = 12'($urandom);
    if (loop_off) begin
      corr_m = tgt_m; lcnt = 0;
    end else begin
      lcnt++;
      eff = (line_div == 0) ? 1 : int'(line_div);
      if (lcnt >= eff) begin corr_m = upd(corr_m, a, n); lcnt = 0; end
    end
    @(negedge clk);
    chk(req, corr, corr_m);
  endtask

  task automatic idle(int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      sample = 12'($urandom);
    end
    chk("R3 idle", corr, corr_m);
  endtask

  task automatic load_tgt(int v);
    @(negedge clk); tgt_ld = 1'b1; tgt_data = 8'(v);
    @(negedge clk); tgt_ld = 1'b0; tgt_m = v;
    @(negedge clk);
    if (loop_off) corr_m = v;
  endtask

  task automatic set_pol(bit p);
    @(negedge clk); win_pol = p; win_in = ~p;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    seed_dummy = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk("R1 reset corr", corr, 128);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset corr after release", corr, 128);

    // R8 open loop follows target, R2 target load
    loop_off = 1'b1;
    load_tgt(200);
    chk("R2 R8 open-loop target", corr, 200);
    do_window(20, 0, 4095, "R8 window ignored when off");
    // R9 soft reset
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0; tgt_m = 128; corr_m = 128; lcnt = 0;
    chk("R9 soft reset corr", corr, 128);
    @(negedge clk);
    chk("R9 target back to 128", corr, 128);

    // closed loop, active high, divide by 1
    loop_off = 1'b0; line_div = 4'd1;
    load_tgt(64);
    chk("R2 load no effect when closed", corr, corr_m);
    do_window(20, 40, 50, "R5 window near target");
    idle(7);
    do_window(16, 90, 100, "R5 sample above target");
    do_window(1, 0, 0, "R10 one-sample window");
    do_window(5, 10, 12, "R10 five-sample window");
    idle(4);

    // R6 saturation
    load_tgt(255);
    for (int k = 0; k < 6; k++) do_window(20, 0, 0, "R6 saturate high");
    chk("R6 top clamp", corr, 255);
    load_tgt(0);
    do_window(20, 4095, 4095, "R6 saturate low");
    chk("R6 bottom clamp", corr, 0);

    // R4 active-low strobe
    load_tgt(128);
    set_pol(1'b0);
    idle(5);
    do_window(24, 60, 70, "R4 active-low window");
    set_pol(1'b1);
    idle(3);

    // R7 line divider
    line_div = 4'd3;
    do_window(20, 0, 10, "R7 first of three skipped");
    do_window(20, 0, 10, "R7 second of three skipped");
    do_window(20, 0, 10, "R7 third window updates");
    line_div = 4'd0;
    do_window(20, 500, 520, "R7 zero acts as one");

    // random mix
    for (int k = 0; k < 60; k++) begin
      int lo = int'($urandom % 400);
      if ($urandom % 5 == 0) set_pol(1'($urandom));
      if ($urandom % 6 == 0) load_tgt(int'($urandom % 256));
      if ($urandom % 8 == 0) line_div = 4'($urandom % 4);
      do_window(1 + int'($urandom % 30), lo, lo + int'($urandom % 64), "R5 R7 random window");
      idle(1 + int'($urandom % 4));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule